// File: doc/BRIEF.md
# Fine-Grained Multithreaded Thread Selector

This block decides, once per clock, which hardware thread context may place its next instruction into a deep, single-issue pipeline. It supports 200 contexts by default and picks at most one of them each cycle. Every context has its own small state machine. Two things make a context ineligible. The first is a fetched branch whose target has not yet come back. The second is a data-cache miss that is still being serviced.

The fetch stage tells the block when it has fetched a branch for a thread. The branch unit tells it when that branch resolves, and the redirect then takes a fixed number of extra cycles to reach fetch. The memory stage reports each access as a hit or a miss. A miss holds its thread back for a fixed number of cycles and occupies one entry of a shared pool of miss slots. When a miss arrives while every slot is taken, the block raises a global stall in that same cycle. It refuses the miss, so the memory stage presents it again later. During the stall no thread is selected and the round-robin pointer stays where it is.

Per-context states and transitions: `CTX_READY` goes to `CTX_BR_WAIT` on a branch fetch. `CTX_BR_WAIT` goes to `CTX_REDIRECT` on branch resolve. `CTX_REDIRECT` goes back to `CTX_READY` when the redirect countdown expires. `CTX_READY` or `CTX_BR_WAIT` goes to `CTX_MISS_WAIT` on an accepted miss. `CTX_MISS_WAIT` goes back to `CTX_READY` when the miss countdown expires, and that same transition releases the miss slot. Where events coincide, an accepted miss wins over a resolve, and a resolve wins over a branch fetch.

Top module: `fgmt_thread_sel`

## Requirements
- R1: A synchronous reset (`rst` high) leaves every context eligible, frees every miss slot and points the pointer at the last context. In the first cycle after reset, `sel_valid`=1, `sel_tid`=0 and `stall`=0.
- R2: With every context eligible, the selection advances by one each cycle (0, 1, 2, ...) and wraps from `N_CTX-1` back to 0.
- R3: Selection skips ineligible contexts and takes the first eligible one after the last selected context. When no context is eligible, `sel_valid` is 0.
- R4: A branch fetch (`brf_vld`) makes its context ineligible from the next cycle on. A resolve (`brr_vld`) for that context keeps it ineligible for `REDIRECT_LAT` further cycles (default 1). It is eligible again in the cycle after that.
- R5: A memory access with `mem_miss`=0 (a hit) leaves its context eligible and takes no miss slot.
- R6: An accepted miss makes its context ineligible for exactly `MISS_LAT` cycles (default 100), counted from the cycle after the miss. It is eligible in the next cycle.
- R7: At most `MISS_SLOTS` misses (default 16) are outstanding. A miss reported while all slots are taken drives `stall`=1 and `sel_valid`=0 in that cycle. The miss is not accepted, so its context stays eligible.
- R8: During a stall cycle the round-robin pointer does not move. The next selection continues after the last context that was actually selected.
- R9: A slot is freed at the clock edge that ends a context's miss wait. A miss in the cycle before that edge still stalls. A miss in the cycle after it is accepted.
- R10: Events that do not match a context's state are ignored: a resolve for a context not waiting on a branch, a miss for a context already in miss wait (no slot taken), and a branch fetch for a context not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brf_vld | input | 1 | A branch was fetched for `brf_tid` |
| brf_tid | input | TID_W | Context of the fetched branch |
| brr_vld | input | 1 | A branch resolved for `brr_tid` |
| brr_tid | input | TID_W | Context of the resolved branch |
| mem_vld | input | 1 | Memory stage reports an access |
| mem_tid | input | TID_W | Context of the access |
| mem_miss | input | 1 | 1 = miss, 0 = hit |
| sel_valid | output | 1 | A context is selected this cycle |
| sel_tid | output | TID_W | Selected context |
| stall | output | 1 | Global pipeline stall: miss with no free slot |

## Verification
The hardest situation to reach is the edge where a full miss pool frees its first slot. It needs sixteen misses outstanding, a duplicate miss that must not take a slot, and probes timed exactly one cycle on either side of the release. To get there, the stimulus first parks every context except context 0 in branch wait by fetching a branch for each of them. That makes context 0's eligibility directly visible on `sel_valid`. It then issues the misses back to back and probes with misses from context 0 at fixed offsets from the first one. A second scenario fills the pool while all contexts are ready, so that the pointer hold during a stall shows up as the selected context number.

// File: rtl/fgmt_pkg.sv
`timescale 1ns/1ps
package fgmt_pkg;

    // Per-context eligibility state
    typedef enum logic [1:0] {
        CTX_READY     = 2'd0,
        CTX_BR_WAIT   = 2'd1,
        CTX_REDIRECT  = 2'd2,
        CTX_MISS_WAIT = 2'd3
    } ctx_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fgmt_ctx.sv
`timescale 1ns/1ps
module fgmt_ctx
    import fgmt_pkg::*;
#(
    parameter int CNT_W        = 7,
    parameter int MISS_LAT     = 100,
    parameter int REDIRECT_LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic brf_hit,
    input  logic brr_hit,
    input  logic miss_take,
    output logic eligible,
    output logic miss_ok,
    output logic release_slot
);

    ctx_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTX_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CTX_READY: begin
                if (miss_take) begin
                    state_d = CTX_MISS_WAIT;
                    cnt_d   = CNT_W'(MISS_LAT);
                end else if (brf_hit) begin
                    state_d = CTX_BR_WAIT;
                end
            end
            CTX_BR_WAIT: begin
                if (miss_take) begin
                    state_d = CTX_MISS_WAIT;
                    cnt_d   = CNT_W'(MISS_LAT);
                end else if (brr_hit) begin
                    state_d = CTX_REDIRECT;
                    cnt_d   = CNT_W'(REDIRECT_LAT);
                end
            end
            CTX_REDIRECT: begin
                if (cnt_q == CNT_W'(1)) begin
                    state_d = CTX_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            CTX_MISS_WAIT: begin
                if (cnt_q == CNT_W'(1)) begin
                    state_d = CTX_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = CTX_READY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        eligible     = (state_q == CTX_READY);
        miss_ok      = (state_q == CTX_READY) || (state_q == CTX_BR_WAIT);
        release_slot = (state_q == CTX_MISS_WAIT) && (cnt_q == CNT_W'(1));
    end

endmodule

// File: rtl/fgmt_rr_pick.sv
`timescale 1ns/1ps
module fgmt_rr_pick #(
    parameter int N_CTX = 200,
    parameter int TID_W = 8
) (
    input  logic [N_CTX-1:0] elig,
    input  logic [TID_W-1:0] last,
    output logic             found,
    output logic [TID_W-1:0] pick
);

    // Search starts one past the last selected context
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N_CTX; k++) begin
            idx = (int'(last) + 1 + k) % N_CTX;
            if (!found && elig[idx]) begin
                found = 1'b1;
                pick  = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/fgmt_miss_pool.sv
`timescale 1ns/1ps
module fgmt_miss_pool #(
    parameter int N_CTX      = 200,
    parameter int MISS_SLOTS = 16,
    parameter int SLOT_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [N_CTX-1:0]  rel_vec,
    output logic              full,
    output logic [SLOT_W-1:0] used
);

    logic [SLOT_W-1:0] rel_n;

    always_comb begin
        rel_n = '0;
        for (int k = 0; k < N_CTX; k++) begin
            rel_n = rel_n + SLOT_W'(rel_vec[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
        end else begin
            used <= used + SLOT_W'(take) - rel_n;
        end
    end

    assign full = (used == SLOT_W'(MISS_SLOTS));

endmodule

// File: rtl/fgmt_thread_sel.sv
`timescale 1ns/1ps
module fgmt_thread_sel
    import fgmt_pkg::*;
#(
    parameter int N_CTX        = 200,
    parameter int MISS_SLOTS   = 16,
    parameter int MISS_LAT     = 100,
    parameter int REDIRECT_LAT = 1,
    localparam int TID_W  = $clog2(N_CTX),
    localparam int CNT_W  = $clog2(max2(MISS_LAT, REDIRECT_LAT) + 1),
    localparam int SLOT_W = $clog2(MISS_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             brf_vld,
    input  logic [TID_W-1:0] brf_tid,
    input  logic             brr_vld,
    input  logic [TID_W-1:0] brr_tid,
    input  logic             mem_vld,
    input  logic [TID_W-1:0] mem_tid,
    input  logic             mem_miss,
    output logic             sel_valid,
    output logic [TID_W-1:0] sel_tid,
    output logic             stall
);

    logic [N_CTX-1:0]  elig_vec;
    logic [N_CTX-1:0]  miss_ok_vec;
    logic [N_CTX-1:0]  rel_vec;
    logic [N_CTX-1:0]  take_vec;
    logic [TID_W-1:0]  last_ptr;
    logic [TID_W-1:0]  pick;
    logic              found;
    logic              pool_full;
    logic              miss_ev;
    logic [SLOT_W-1:0] slots_used;

    assign miss_ev = mem_vld && mem_miss;
    assign stall   = miss_ev && pool_full;

    for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
        logic brf_hit, brr_hit;
        assign brf_hit     = brf_vld && (brf_tid == TID_W'(i));
        assign brr_hit     = brr_vld && (brr_tid == TID_W'(i));
        assign take_vec[i] = miss_ev && !pool_full && (mem_tid == TID_W'(i)) && miss_ok_vec[i];

        fgmt_ctx #(
            .CNT_W        (CNT_W),
            .MISS_LAT     (MISS_LAT),
            .REDIRECT_LAT (REDIRECT_LAT)
        ) u_ctx (
            .clk          (clk),
            .rst          (rst),
            .brf_hit      (brf_hit),
            .brr_hit      (brr_hit),
            .miss_take    (take_vec[i]),
            .eligible     (elig_vec[i]),
            .miss_ok      (miss_ok_vec[i]),
            .release_slot (rel_vec[i])
        );
    end

    fgmt_miss_pool #(
        .N_CTX      (N_CTX),
        .MISS_SLOTS (MISS_SLOTS),
        .SLOT_W     (SLOT_W)
    ) u_pool (
        .clk     (clk),
        .rst     (rst),
        .take    (|take_vec),
        .rel_vec (rel_vec),
        .full    (pool_full),
        .used    (slots_used)
    );

    fgmt_rr_pick #(
        .N_CTX (N_CTX),
        .TID_W (TID_W)
    ) u_pick (
        .elig  (elig_vec),
        .last  (last_ptr),
        .found (found),
        .pick  (pick)
    );

    assign sel_valid = found && !stall;
    assign sel_tid   = pick;

    // Round-robin pointer; held while stalled
    always_ff @(posedge clk) begin
        if (rst) begin
            last_ptr <= TID_W'(N_CTX - 1);
        end else if (sel_valid) begin
            last_ptr <= pick;
        end
    end

endmodule

// File: rtl/fgmt_thread_sel_chk.sv
`timescale 1ns/1ps
module fgmt_thread_sel_chk #(
    parameter int N_CTX  = 200,
    parameter int TID_W  = 8,
    parameter int SLOT_W = 5,
    parameter int MISS_SLOTS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_valid,
    input logic [TID_W-1:0]  sel_tid,
    input logic              stall,
    input logic              mem_vld,
    input logic              mem_miss,
    input logic [N_CTX-1:0]  elig,
    input logic [TID_W-1:0]  last_ptr,
    input logic [SLOT_W-1:0] used
);

    // R3: a selected context must be eligible
    a_r3_pick_eligible: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (int'(sel_tid) < N_CTX) && elig[sel_tid]);

    // R3: a bubble without stall means nobody is eligible
    a_r3_bubble_empty: assert property (@(posedge clk) disable iff (rst)
        (!sel_valid && !stall) |-> (elig == '0));

    // R7: stall suppresses selection and only follows a reported miss
    a_r7_stall_no_sel: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!sel_valid && mem_vld && mem_miss));

    // R7: never more than the slot limit outstanding
    a_r7_slot_cap: assert property (@(posedge clk) disable iff (rst)
        int'(used) <= MISS_SLOTS);

    // R8: pointer holds across a stall cycle
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> (last_ptr == $past(last_ptr)));

    // R9: occupancy moves by at most one per cycle
    a_r9_slot_step: assert property (@(posedge clk) disable iff (rst)
        (used == $past(used)) || (used == $past(used) + SLOT_W'(1)) ||
        (used + SLOT_W'(1) == $past(used)));

endmodule

bind fgmt_thread_sel fgmt_thread_sel_chk #(
    .N_CTX      (N_CTX),
    .TID_W      (TID_W),
    .SLOT_W     (SLOT_W),
    .MISS_SLOTS (MISS_SLOTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_valid (sel_valid),
    .sel_tid   (sel_tid),
    .stall     (stall),
    .mem_vld   (mem_vld),
    .mem_miss  (mem_miss),
    .elig      (elig_vec),
    .last_ptr  (last_ptr),
    .used      (slots_used)
);

// File: tb/fgmt_thread_sel_bench.sv
`timescale 1ns/1ps
module fgmt_thread_sel_bench;

    localparam int N  = 200;
    localparam int TW = 8;

    typedef struct packed {
        logic          brf_v;
        logic [TW-1:0] brf_t;
        logic          brr_v;
        logic [TW-1:0] brr_t;
        logic          mem_v;
        logic [TW-1:0] mem_t;
        logic          miss;
        logic          ev;
        logic [TW-1:0] et;
        logic          es;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TAB [NV] = '{
        '{1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b1, 8'd0, 1'b0}, // R1 first pick
        '{1'b1, 8'd2, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b1, 8'd1, 1'b0}, // branch on 2
        '{1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b1, 8'd3, 1'b0}, // R3 skip 2
        '{1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd4, 1'b0, 1'b1, 8'd4, 1'b0}, // hit on 4
        '{1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd5, 1'b1, 1'b1, 8'd5, 1'b0}, // miss on 5
        '{1'b0, 8'd0, 1'b1, 8'd7, 1'b0, 8'd0, 1'b0, 1'b1, 8'd6, 1'b0}, // stray resolve 7
        '{1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b1, 8'd7, 1'b0}, // R10 7 still ok
        '{1'b0, 8'd0, 1'b1, 8'd2, 1'b0, 8'd0, 1'b0, 1'b1, 8'd8, 1'b0}, // resolve 2
        '{1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 1'b1, 8'd9, 1'b0}  // R2 next
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          brf_vld = 1'b0, brr_vld = 1'b0, mem_vld = 1'b0, mem_miss = 1'b0;
    logic [TW-1:0] brf_tid = '0, brr_tid = '0, mem_tid = '0;
    logic          sel_valid, stall;
    logic [TW-1:0] sel_tid;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fgmt_thread_sel u_fgmt_thread_sel (
        .clk       (clk),
        .rst       (rst),
        .brf_vld   (brf_vld),
        .brf_tid   (brf_tid),
        .brr_vld   (brr_vld),
        .brr_tid   (brr_tid),
        .mem_vld   (mem_vld),
        .mem_tid   (mem_tid),
        .mem_miss  (mem_miss),
        .sel_valid (sel_valid),
        .sel_tid   (sel_tid),
        .stall     (stall)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        brf_vld = 1'b0; brr_vld = 1'b0; mem_vld = 1'b0; mem_miss = 1'b0;
    endtask

    // Called at a negedge; drives inputs for this cycle
    task automatic set_ev(input logic bv, input int bt, input logic rv, input int rt,
                          input logic mv, input int mt, input logic ms);
        brf_vld = bv; brf_tid = TW'(bt);
        brr_vld = rv; brr_tid = TW'(rt);
        mem_vld = mv; mem_tid = TW'(mt); mem_miss = ms;
        #1;
    endtask

    task automatic next_cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle();
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // ---------------- table walk ----------------
        do_reset();
        #1;
        chk("R1 stall after reset", int'(stall), 0);
        for (int v = 0; v < NV; v++) begin
            set_ev(TAB[v].brf_v, int'(TAB[v].brf_t), TAB[v].brr_v, int'(TAB[v].brr_t),
                   TAB[v].mem_v, int'(TAB[v].mem_t), TAB[v].miss);
            chk("R1/R2/R3/R10 table valid", int'(sel_valid), int'(TAB[v].ev));
            chk("R1/R2/R3/R10 table tid",   int'(sel_tid),   int'(TAB[v].et));
            chk("R7 table stall",           int'(stall),     int'(TAB[v].es));
            next_cyc();
        end

        // ---------------- R2 wrap ----------------
        do_reset();
        for (int c = 0; c <= N; c++) begin
            set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
            if (int'(sel_tid) != (c % N) || !sel_valid)
                chk("R2 round robin order", int'(sel_tid), c % N);
            else
                total++;
            next_cyc();
        end

        // ---------------- R8 pointer hold ----------------
        do_reset();
        for (int c = 0; c < 16; c++) begin
            set_ev(1'b0, 0, 1'b0, 0, 1'b1, 100 + c, 1'b1);
            if (stall) chk("R7 fill no stall", int'(stall), 0);
            next_cyc();
        end
        set_ev(1'b0, 0, 1'b0, 0, 1'b1, 0, 1'b1);
        chk("R7 full stall", int'(stall), 1);
        chk("R7 full no valid", int'(sel_valid), 0);
        next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R8 pointer held tid", int'(sel_tid), 16);
        chk("R8 pointer held valid", int'(sel_valid), 1);
        next_cyc();

        // ---------------- isolate context 0 ----------------
        do_reset();
        for (int t = 1; t < N; t++) begin
            set_ev(1'b1, t, 1'b0, 0, 1'b0, 0, 1'b0);
            next_cyc();
        end
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R3 only ctx0 tid", int'(sel_tid), 0);
        chk("R3 only ctx0 valid", int'(sel_valid), 1);
        next_cyc();
        // R10: second branch fetch on a blocked context is ignored; still blocked
        set_ev(1'b1, 5, 1'b0, 0, 1'b1, 0, 1'b0);  // plus hit on ctx0
        next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R5 hit keeps ctx0 eligible", int'(sel_valid), 1);
        chk("R5 hit keeps tid", int'(sel_tid), 0);
        next_cyc();

        // R4 branch timing
        set_ev(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R4 branch cycle still valid", int'(sel_valid), 1);
        next_cyc();
        for (int c = 0; c < 3; c++) begin
            set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
            chk("R3 R4 none eligible", int'(sel_valid), 0);
            next_cyc();
        end
        set_ev(1'b0, 0, 1'b1, 0, 1'b0, 0, 1'b0);
        chk("R4 resolve cycle", int'(sel_valid), 0);
        next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R4 redirect cycle", int'(sel_valid), 0);
        next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R4 eligible after redirect", int'(sel_valid), 1);
        next_cyc();

        // R6 miss latency
        set_ev(1'b0, 0, 1'b0, 0, 1'b1, 0, 1'b1);
        chk("R6 miss cycle valid", int'(sel_valid), 1);
        next_cyc();
        begin
            int blocked = 0;
            for (int c = 0; c < 100; c++) begin
                set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
                if (!sel_valid) blocked++;
                next_cyc();
            end
            chk("R6 cycles blocked", blocked, 100);
        end
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
        chk("R6 eligible after wait", int'(sel_valid), 1);
        next_cyc();

        // R7 / R9 / R10 slot pool
        begin
            int stalls = 0;
            set_ev(1'b0, 0, 1'b0, 0, 1'b1, 1, 1'b1);          // step 0
            if (stall) stalls++;
            next_cyc();
            set_ev(1'b0, 0, 1'b0, 0, 1'b1, 1, 1'b1);          // step 1 duplicate
            if (stall) stalls++;
            next_cyc();
            for (int t = 2; t <= 16; t++) begin               // steps 2..16
                set_ev(1'b0, 0, 1'b0, 0, 1'b1, t, 1'b1);
                if (stall) stalls++;
                next_cyc();
            end
            chk("R10 duplicate miss takes no slot", stalls, 0);
        end
        set_ev(1'b0, 0, 1'b0, 0, 1'b1, 0, 1'b1);              // step 17
        chk("R7 stall when full", int'(stall), 1);
        chk("R7 no valid when full", int'(sel_valid), 0);
        next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);              // step 18
        chk("R7 refused miss leaves ctx0 eligible", int'(sel_valid), 1);
        chk("R7 refused miss tid", int'(sel_tid), 0);
        next_cyc();
        for (int s = 19; s < 100; s++) next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b1, 0, 1'b1);              // step 100
        chk("R9 still full before release", int'(stall), 1);
        next_cyc();
        set_ev(1'b0, 0, 1'b0, 0, 1'b1, 0, 1'b1);              // step 101
        chk("R9 accepted after release", int'(stall), 0);
        chk("R9 released ctx selected", int'(sel_tid), 1);
        next_cyc();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule